// File: doc/BRIEF.md
# Translation Buffer Fill Unit

This block is the write side of a 64-slot translation buffer. Each slot holds a tag and a 64-bit entry word. Within the word, bit 63 marks the slot as valid and bit 6 marks it as locked. A fill request carries a new entry word and installs it in a free slot. The slot is chosen in one cycle by two priority encoders. The first looks for the lowest slot that is not valid. If every slot is valid, the second looks for the lowest slot that is not locked. If every slot is both valid and locked, the fill is dropped and a full pulse is raised instead.

A direct write places an entry at the slot named by address bits 8:3 and ignores the slot's current state. Every installed entry takes its tag from control register 6, the tag staging register. The block also holds a bank of sixteen 64-bit control registers, selected by address bits 6:3. In that bank, register 0 is an identity register that cannot be written, register 3 is the fault status and register 4 is the fault address. A hardware capture input loads both fault registers.

Slot contents and register values can be read back through registered ports with one cycle of latency. This is how surrounding logic and the bench observe the stored state.

Top module: `tlb_fill_unit`

## Requirements
- R1: Synchronous reset clears every slot's valid bit (bit 63), clears all sixteen control registers, and holds `done` and `full` low.
- R2: A fill (`req_kind` = 0) writes the lowest-numbered slot whose valid bit is clear, even when unlocked valid slots exist at lower indices.
- R3: When no slot is invalid, a fill writes the lowest-numbered slot whose lock bit (bit 6) is clear.
- R4: When every slot is valid and locked, a fill changes no slot, raises `full` for one cycle and leaves `done` low.
- R5: An installed slot holds the request's `req_wdata` as its entry word and the value of control register 6 at the time of the request as its tag.
- R6: A direct write (`req_kind` = 1) writes the slot given by `req_addr[8:3]`, whatever that slot's valid and lock bits are. Other address bits have no effect.
- R7: A register write (`req_kind` = 2) targets register `req_addr[6:3]`. Writes to registers 0 and 4 are ignored, and every other register except 3 takes `req_wdata` unchanged.
- R8: A write to register 3 stores `req_wdata` when its bit 0 is 1. When bit 0 is 0, the write clears register 3 to zero and also clears register 4, because the default configuration is the data side.
- R9: `done` and `full` are one-cycle pulses registered at the clock edge that commits the request, and they are never high together.
- R10: A pulse on `flt_capture` loads `flt_status` into register 3 and `flt_addr` into register 4. A register write in the same cycle takes precedence over the capture.
- R11: `rd_tag`/`rd_word` show the slot chosen by `rd_index`, and `reg_data` shows the register chosen by `reg_sel`, each one clock after the selection. The valid bit of `rd_word` reflects the slot's current valid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 0 fill, 1 direct write, 2 register write |
| req_addr | input | 16 | Slot index in bits 8:3, register select in bits 6:3 |
| req_wdata | input | 64 | Entry word or register value |
| flt_capture | input | 1 | Load the fault registers from hardware |
| flt_status | input | 64 | Value captured into register 3 |
| flt_addr | input | 64 | Value captured into register 4 |
| rd_index | input | 6 | Slot selected for readback |
| rd_tag | output | 64 | Tag of the selected slot |
| rd_word | output | 64 | Entry word of the selected slot |
| reg_sel | input | 4 | Register selected for readback |
| reg_data | output | 64 | Value of the selected register |
| done | output | 1 | A slot write was committed |
| full | output | 1 | A fill was dropped |

## Verification
Fills are first swept over an empty buffer, with a new tag staged before each one, to show that slots are taken in index order. The test then sweeps each of the 64 slots, one at a time, as the only unlocked slot in an otherwise locked buffer. This separates the unlocked search from any positional bias. Further tests place one invalid slot above several unlocked ones, to show that the invalid search wins, and fill a buffer that is fully locked, to show that it is left intact. Register writes cover all sixteen selects, and register 3 is written with bit 0 both set and clear, with captured fault values present.

// File: rtl/tlb_fill_pkg.sv
package tlb_fill_pkg;
  typedef enum logic [1:0] {
    REQ_FILL   = 2'd0,
    REQ_DIRECT = 2'd1,
    REQ_REGWR  = 2'd2,
    REQ_NONE   = 2'd3
  } req_kind_e;
endpackage

// File: rtl/tlb_lowest_zero.sv
module tlb_lowest_zero #(
  parameter int N     = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // scan from the top so the lowest clear bit wins
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vec[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_slot_picker.sv
module tlb_slot_picker #(
  parameter int N     = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     lock_vec,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_ok
);
  logic [IDX_W-1:0] cand_idx [2];
  logic [1:0]       cand_any;
  logic [N-1:0]     scan_vec [2];

  assign scan_vec[0] = valid_vec;
  assign scan_vec[1] = lock_vec;

  for (genvar p = 0; p < 2; p++) begin : g_pass
    tlb_lowest_zero #(.N(N)) u_enc (
      .vec (scan_vec[p]),
      .idx (cand_idx[p]),
      .any (cand_any[p])
    );
  end

  // pass 0 (invalid) outranks pass 1 (unlocked)
  assign pick_idx = cand_any[0] ? cand_idx[0] : cand_idx[1];
  assign pick_ok  = |cand_any;
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N         = 64,
  parameter int TAG_W     = 64,
  parameter int DATA_W    = 64,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [N-1:0]      valid_vec,
  output logic [N-1:0]      lock_vec,
  output logic [TAG_W-1:0]  rtag,
  output logic [DATA_W-1:0] rdata
);
  logic [TAG_W-1:0]  tag_mem  [N];
  logic [DATA_W-1:0] data_mem [N];
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // plain arrays, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx]  <= wtag;
      data_mem[widx] <= wdata;
    end
    rtag    <= tag_mem[ridx];
    rdata_q <= data_mem[ridx];
  end

  // flag shadows kept in flops for the one-cycle search
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      lock_vec  <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      if (we) begin
        valid_vec[widx] <= wdata[VALID_BIT];
        lock_vec[widx]  <= wdata[LOCK_BIT];
      end
      rvalid_q <= valid_vec[ridx];
    end
  end

  always_comb begin
    rdata            = rdata_q;
    rdata[VALID_BIT] = rvalid_q;
  end

  AST_WRITE_SETS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    we |=> (valid_vec[$past(widx)] == $past(wdata[VALID_BIT]))
        && (lock_vec[$past(widx)] == $past(wdata[LOCK_BIT]))); // R5
endmodule

// File: rtl/tlb_ctrl_regs.sv
module tlb_ctrl_regs #(
  parameter int REG_W     = 64,
  parameter int NREGS     = 16,
  parameter bit DATA_SIDE = 1'b1,
  parameter int RO_REG    = 0,
  parameter int FSR_REG   = 3,
  parameter int FAR_REG   = 4,
  parameter int TAG_REG   = 6,
  localparam int SEL_W    = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [REG_W-1:0] wdata,
  input  logic             cap_en,
  input  logic [REG_W-1:0] cap_status,
  input  logic [REG_W-1:0] cap_addr,
  input  logic [SEL_W-1:0] rsel,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] tag_value
);
  logic [REG_W-1:0] regs [NREGS];
  logic             fsr_clear;

  assign fsr_clear = we && (wsel == SEL_W'(FSR_REG)) && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
      rdata <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (r == RO_REG) begin
          regs[r] <= regs[r];
        end else if (r == FAR_REG) begin
          if (DATA_SIDE && fsr_clear) regs[r] <= '0;
          else if (cap_en)            regs[r] <= cap_addr;
        end else if (r == FSR_REG) begin
          if (we && wsel == SEL_W'(r)) regs[r] <= wdata[0] ? wdata : '0;
          else if (cap_en)             regs[r] <= cap_status;
        end else if (we && wsel == SEL_W'(r)) begin
          regs[r] <= wdata;
        end
      end
      rdata <= regs[rsel];
    end
  end

  assign tag_value = regs[TAG_REG];

  AST_RO_REG_STABLE: assert property (@(posedge clk) disable iff (rst)
    $stable(regs[RO_REG])); // R7

  AST_FSR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    fsr_clear |=> (regs[FSR_REG] == '0)); // R8

  if (DATA_SIDE) begin : g_far_chk
    AST_FAR_CLEARED: assert property (@(posedge clk) disable iff (rst)
      fsr_clear |=> (regs[FAR_REG] == '0)); // R8
  end
endmodule

// File: rtl/tlb_fill_unit.sv
module tlb_fill_unit
  import tlb_fill_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int DATA_W    = 64,
  parameter int REG_W     = 64,
  parameter int NREGS     = 16,
  parameter int ADDR_W    = 16,
  parameter bit DATA_SIDE = 1'b1,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int SEL_W    = $clog2(NREGS),
  localparam int IDX_LSB  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              flt_capture,
  input  logic [REG_W-1:0]  flt_status,
  input  logic [REG_W-1:0]  flt_addr,
  input  logic [IDX_W-1:0]  rd_index,
  output logic [REG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_word,
  input  logic [SEL_W-1:0]  reg_sel,
  output logic [REG_W-1:0]  reg_data,
  output logic              done,
  output logic              full
);
  req_kind_e        kind;
  logic             fill_go, dir_go, reg_go;
  logic [ENTRIES-1:0] valid_vec, lock_vec;
  logic [IDX_W-1:0] pick_idx, wr_idx;
  logic             pick_ok, wr_en;
  logic [REG_W-1:0] tag_value;
  logic [REG_W-1:0] reg_wdata;

  assign kind    = req_kind_e'(req_kind);
  assign fill_go = req_valid && (kind == REQ_FILL);
  assign dir_go  = req_valid && (kind == REQ_DIRECT);
  assign reg_go  = req_valid && (kind == REQ_REGWR);

  tlb_slot_picker #(.N(ENTRIES)) u_picker (
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .pick_idx  (pick_idx),
    .pick_ok   (pick_ok)
  );

  assign wr_en  = dir_go || (fill_go && pick_ok);
  assign wr_idx = dir_go ? req_addr[IDX_LSB +: IDX_W] : pick_idx;

  tlb_entry_store #(
    .N(ENTRIES), .TAG_W(REG_W), .DATA_W(DATA_W),
    .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en),
    .widx      (wr_idx),
    .wtag      (tag_value),
    .wdata     (req_wdata),
    .ridx      (rd_index),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .rtag      (rd_tag),
    .rdata     (rd_word)
  );

  assign reg_wdata = REG_W'(req_wdata);

  tlb_ctrl_regs #(
    .REG_W(REG_W), .NREGS(NREGS), .DATA_SIDE(DATA_SIDE)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_go),
    .wsel       (req_addr[IDX_LSB +: SEL_W]),
    .wdata      (reg_wdata),
    .cap_en     (flt_capture),
    .cap_status (flt_status),
    .cap_addr   (flt_addr),
    .rsel       (reg_sel),
    .rdata      (reg_data),
    .tag_value  (tag_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      full <= 1'b0;
    end else begin
      done <= wr_en;
      full <= fill_go && !pick_ok;
    end
  end

  AST_DONE_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && full)); // R9

  AST_FULL_ONLY_SATURATED: assert property (@(posedge clk) disable iff (rst)
    full |-> $past(&(valid_vec & lock_vec))); // R4

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (fill_go && &(valid_vec & lock_vec)) |=> ($stable(valid_vec) && $stable(lock_vec))); // R4

  AST_FILL_TAKES_INVALID: assert property (@(posedge clk) disable iff (rst)
    (fill_go && !(&valid_vec)) |=> done); // R2
endmodule

// File: tb/tlb_fill_unit_tb.sv
module tlb_fill_unit_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd3;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        flt_capture = 1'b0;
  logic [63:0] flt_status = '0;
  logic [63:0] flt_addr = '0;
  logic [5:0]  rd_index = '0;
  logic [63:0] rd_tag, rd_word;
  logic [3:0]  reg_sel = '0;
  logic [63:0] reg_data;
  logic        done, full;

  int checks = 0;
  int fails = 0;

  logic [63:0] m_tag  [N];
  logic [63:0] m_word [N];
  logic [63:0] m_reg6;

  always #5 clk = ~clk;

  tlb_fill_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .flt_capture(flt_capture),
    .flt_status(flt_status), .flt_addr(flt_addr), .rd_index(rd_index),
    .rd_tag(rd_tag), .rd_word(rd_word), .reg_sel(reg_sel),
    .reg_data(reg_data), .done(done), .full(full)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // drive one request; done/full are sampled after the commit edge, then once more
  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [63:0] d,
                       input bit exp_done, input bit exp_full, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd3;
    check({rq, " done"}, {63'd0, done}, {63'd0, exp_done});
    check({rq, " full"}, {63'd0, full}, {63'd0, exp_full});
    @(negedge clk);
    check("R9 pulse ends", {62'd0, done, full}, 64'd0);
  endtask

  task automatic set_tag(input logic [63:0] t);
    issue(2'd2, 16'(6 << 3), t, 1'b0, 1'b0, "R7 tag write");
    m_reg6 = t;
  endtask

  task automatic read_slot(input int idx, input string rq);
    @(negedge clk);
    rd_index = 6'(idx);
    @(negedge clk);
    check({rq, " tag"}, rd_tag, m_tag[idx]);
    check({rq, " word"}, rd_word, m_word[idx]);
  endtask

  task automatic read_reg(input int sel, input logic [63:0] exp, input string rq);
    @(negedge clk);
    reg_sel = 4'(sel);
    @(negedge clk);
    check(rq, reg_data, exp);
  endtask

  // lowest invalid slot, else lowest unlocked slot, else -1
  function automatic int model_slot();
    for (int i = 0; i < N; i++) if (!m_word[i][63]) return i;
    for (int i = 0; i < N; i++) if (!m_word[i][6]) return i;
    return -1;
  endfunction

  task automatic fill(input logic [63:0] w, input int exp_slot, input string rq);
    int s;
    s = model_slot();
    check({rq, " model slot"}, 64'(s), 64'(exp_slot));
    issue(2'd0, 16'h0000, w, s >= 0, s < 0, rq);
    if (s >= 0) begin
      m_tag[s] = m_reg6; m_word[s] = w;
      read_slot(s, rq);
    end
  endtask

  task automatic direct(input int idx, input logic [63:0] w, input string rq);
    issue(2'd1, {7'h5a, 6'(idx), 3'b101}, w, 1'b1, 1'b0, rq);
    m_tag[idx] = m_reg6; m_word[idx] = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_reg6 = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_word[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 full", {63'd0, full}, 64'd0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_index = 6'(i);
      @(negedge clk); check("R1 valid clear", {63'd0, rd_word[63]}, 64'd0);
    end
    for (int s = 0; s < 16; s++) read_reg(s, 64'd0, "R1 reg zero");

    // R2/R5 fill an empty buffer in order, fresh tag each time
    for (int i = 0; i < N; i++) begin
      set_tag(64'hA5A5_0000_0000_0000 | 64'(i * 257));
      fill(64'h8000_0000_0000_0000 | 64'(i << 12), i, "R2 R5 empty fill");
    end

    // R6 lock slots 0..9 by direct write
    set_tag(64'h0000_0000_0000_00D1);
    for (int i = 0; i < 10; i++)
      direct(i, 64'h8000_0000_0000_0040 | 64'(i << 20), "R6 direct lock");
    for (int i = 0; i < 10; i++) read_slot(i, "R6 direct readback");

    // R2 an invalid slot above unlocked ones wins
    direct(40, 64'h0000_0000_0003_0000, "R6 direct invalid");
    fill(64'h8000_0000_0004_0000, 40, "R2 invalid beats unlocked");
    // R3 no invalid slot: lowest unlocked, twice
    fill(64'h8000_0000_0005_0000, 10, "R3 lowest unlocked");
    fill(64'h8000_0000_0006_0000, 10, "R3 unlocked reused");

    // R6 lock everything, including already-locked slots
    set_tag(64'h0000_0000_0000_00E2);
    for (int i = 0; i < N; i++)
      direct(i, 64'hC000_0000_0000_0040 | 64'(i << 24), "R6 direct all");

    // R4 saturated buffer drops fill
    fill(64'h8000_0000_0007_0000, -1, "R4 drop");
    for (int i = 0; i < N; i++) read_slot(i, "R4 unchanged");

    // R3 sweep: one unlocked slot at each position
    for (int j = 0; j < N; j++) begin
      direct(j, 64'h8000_0000_0000_0000 | 64'(j << 8), "R6 unlock");
      fill(64'h8000_0000_0000_0040 | 64'(j << 16), j, "R3 sweep");
    end
    fill(64'h8000_0000_0008_0000, -1, "R4 drop again");

    // R7 register writes across all selects (bit0 set)
    for (int s = 0; s < 16; s++)
      issue(2'd2, 16'(s << 3), {4'(s), 56'h0, 4'h1}, 1'b0, 1'b0, "R7 reg write");
    for (int s = 0; s < 16; s++)
      read_reg(s, (s == 0 || s == 4) ? 64'd0 : {4'(s), 56'h0, 4'h1}, "R7 R8 reg value");

    // R10 capture
    @(negedge clk);
    flt_capture = 1'b1; flt_status = 64'h0000_0000_0000_0F0B; flt_addr = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    flt_capture = 1'b0;
    read_reg(3, 64'h0000_0000_0000_0F0B, "R10 status captured");
    read_reg(4, 64'h1234_5678_9ABC_DEF0, "R10 addr captured");
    // R7 write to register 4 ignored
    issue(2'd2, 16'(4 << 3), 64'hFFFF, 1'b0, 1'b0, "R7 reg4 write");
    read_reg(4, 64'h1234_5678_9ABC_DEF0, "R7 reg4 kept");
    // R8 bit0 set keeps value and leaves fault address
    issue(2'd2, 16'(3 << 3), 64'h0000_0000_00AA_0001, 1'b0, 1'b0, "R8 fsr write");
    read_reg(3, 64'h0000_0000_00AA_0001, "R8 fsr stored");
    read_reg(4, 64'h1234_5678_9ABC_DEF0, "R8 far untouched");
    // R8 bit0 clear wipes both
    issue(2'd2, 16'(3 << 3), 64'h0000_0000_00AA_00F0, 1'b0, 1'b0, "R8 fsr clear");
    read_reg(3, 64'd0, "R8 fsr cleared");
    read_reg(4, 64'd0, "R8 far cleared");
    // R11 latency: selection change shows after one clock
    read_reg(6, {4'd6, 56'h0, 4'h1}, "R11 reg readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule